// File: doc/BRIEF.md
# GPIO Pad Configuration and Event Detector

This block controls one general-purpose I/O pad through a single 32-bit configuration word. A host writes the word through a one-cycle write strobe and can read it back at any time on a read bus that is always valid. The word sets the pad's output value, enables or disables the output driver and the input receiver, and stores a pad mode. Four routing enables are also held in the word and brought out as pins for the interrupt fabric.

The pad input passes through a two-stage synchronizer. The synchronized value is shown in a read-only bit of the word. It is then optionally inverted and sent to an event detector. A two-bit field selects level detection, single-edge detection, detection on both edges, or no detection. Falling-edge and active-low detection have no codes of their own: they are the edge and level codes with the inversion bit set. The event output goes to a downstream status bank. In level mode it is a level, and in the edge modes it is a one-cycle pulse. GPIO output and event detection act only while the pad mode is zero. Any other mode value hands the pad to a native function.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rd_data` reads 0x0000_0300, `pad_oe` is 0 and `evt` is 0.
- R2: A write stores only the writable bits (mask 0x069E_3F01: bits 0, 8, 9, 13:10, 20:17, 23, 26:25). Every other bit reads 0, and host writes to bit 1 are ignored.
- R3: When the receiver is enabled (bit 9 = 0), bit 1 of `rd_data` shows the value of `pad_in` from two rising edges earlier. When bit 9 = 1, bit 1 reads 0.
- R4: `pad_oe` is 1 exactly when the mode (bits 13:10) is 0 and the driver-disable bit 8 is 0. `pad_out` equals bit 0 when the mode is 0, and is 0 otherwise.
- R5: With detection code 0 (bits 26:25), `evt` is high for as long as the conditioned input is 1.
- R6: With detection code 1, `evt` pulses for one cycle when the conditioned input goes from 0 to 1. Two edge-mode events never occur in consecutive cycles.
- R7: With detection code 3, `evt` pulses for one cycle on every change of the conditioned input.
- R8: With detection code 2, `evt` stays 0.
- R9: Bit 23 inverts the synchronized input before detection. Code 1 with inversion therefore detects falling edges, and code 0 with inversion detects an active-low level.
- R10: When bit 9 is 1, the conditioned input is held at 0 and `evt` stays 0.
- R11: When the mode is nonzero, `evt` and `pad_oe` are both 0.
- R12: `route_en[3:0]` equals bits 20:17 of the stored word, with bit 20 on `route_en[3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the configuration word |
| wr_data | input | 32 | Host write data |
| rd_data | output | 32 | Configuration word with the live input-state bit |
| pad_in | input | 1 | Raw pad input, asynchronous |
| pad_out | output | 1 | Value driven on the pad |
| pad_oe | output | 1 | Pad output enable |
| evt | output | 1 | Event level or pulse toward the status bank |
| route_en | output | 4 | Stored interrupt routing enables |

## Verification
The assertions check, on every cycle, the invariants that need no input history. These are the reserved bits reading zero, the output-enable gating by mode and driver bit, silence while detection is off, while the receiver is off or while the mode is nonzero, the routing pins tracking the word, the reset value, and the rule that edge-mode events never fall in adjacent cycles. Only the bench scenarios can show the two-cycle latency from the pad to the state bit and to the detector. They also show that a pulse fires on the right transition of the inverted or non-inverted input, that the both-edge mode catches falling changes, and that a level follows the input for its whole duration.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;

    localparam int unsigned CFG_W = 32;

    // bit positions inside the configuration word
    localparam int unsigned B_TXVAL  = 0;
    localparam int unsigned B_RXST   = 1;
    localparam int unsigned B_TXDIS  = 8;
    localparam int unsigned B_RXDIS  = 9;
    localparam int unsigned B_MODE   = 10;
    localparam int unsigned MODE_W   = 4;
    localparam int unsigned B_ROUTE  = 17;
    localparam int unsigned ROUTE_W  = 4;
    localparam int unsigned B_INV    = 23;
    localparam int unsigned B_EVSEL  = 25;

    localparam logic [CFG_W-1:0] WR_MASK   = 32'h069E_3F01;
    localparam logic [CFG_W-1:0] RST_WORD  = 32'h0000_0300;

    typedef enum logic [1:0] {
        EV_LEVEL = 2'd0,
        EV_EDGE  = 2'd1,
        EV_OFF   = 2'd2,
        EV_BOTH  = 2'd3
    } ev_sel_e;

    typedef struct packed {
        ev_sel_e              ev_sel;
        logic                 inv;
        logic [ROUTE_W-1:0]   route;
        logic [MODE_W-1:0]    mode;
        logic                 rx_dis;
        logic                 tx_dis;
        logic                 tx_val;
    } pad_fields_t;

    function automatic pad_fields_t decode_word(input logic [CFG_W-1:0] w);
        pad_fields_t f;
        f.ev_sel = ev_sel_e'(w[B_EVSEL +: 2]);
        f.inv    = w[B_INV];
        f.route  = w[B_ROUTE +: ROUTE_W];
        f.mode   = w[B_MODE +: MODE_W];
        f.rx_dis = w[B_RXDIS];
        f.tx_dis = w[B_TXDIS];
        f.tx_val = w[B_TXVAL];
        return f;
    endfunction

endpackage

// File: rtl/pad_cfg_reg.sv
module pad_cfg_reg
    import gpio_pad_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] word_q,
    output pad_fields_t      fields
);
    always_ff @(posedge clk) begin
        if (rst)
            word_q <= RST_WORD;
        else if (wr_en)
            word_q <= wr_data & WR_MASK;
    end

    assign fields = decode_word(word_q);
endmodule

// File: rtl/pad_in_sync.sv
module pad_in_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

    logic [N-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[N-2:0], d};
    end

    assign q = chain[N-1];
endmodule

// File: rtl/pad_evt_det.sv
module pad_evt_det
    import gpio_pad_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    s_in,
    input  logic    rx_dis,
    input  logic    inv,
    input  logic    gpio_mode,
    input  ev_sel_e ev_sel,
    output logic    evt
);
    logic cond;
    logic cond_prev;
    logic raw_evt;

    assign cond = ~rx_dis & (s_in ^ inv);

    always_ff @(posedge clk) begin
        if (rst)
            cond_prev <= 1'b0;
        else
            cond_prev <= cond;
    end

    always_comb begin
        unique case (ev_sel)
            EV_LEVEL: raw_evt = cond;
            EV_EDGE:  raw_evt = cond & ~cond_prev;
            EV_BOTH:  raw_evt = cond ^ cond_prev;
            default:  raw_evt = 1'b0;
        endcase
    end

    assign evt = raw_evt & gpio_mode & ~rx_dis;
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_pad_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CFG_W-1:0]     wr_data,
    output logic [CFG_W-1:0]     rd_data,
    input  logic                 pad_in,
    output logic                 pad_out,
    output logic                 pad_oe,
    output logic                 evt,
    output logic [ROUTE_W-1:0]   route_en
);
    logic [CFG_W-1:0] word_q;
    pad_fields_t      f;
    logic             s_in;
    logic             rx_seen;
    logic             gpio_mode;

    pad_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .word_q  (word_q),
        .fields  (f)
    );

    pad_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (s_in)
    );

    assign gpio_mode = (f.mode == '0);

    pad_evt_det u_det (
        .clk       (clk),
        .rst       (rst),
        .s_in      (s_in),
        .rx_dis    (f.rx_dis),
        .inv       (f.inv),
        .gpio_mode (gpio_mode),
        .ev_sel    (f.ev_sel),
        .evt       (evt)
    );

    assign rx_seen  = s_in & ~f.rx_dis;
    assign rd_data  = word_q | ({{(CFG_W-1){1'b0}}, rx_seen} << B_RXST);
    assign pad_oe   = gpio_mode & ~f.tx_dis;
    assign pad_out  = gpio_mode & f.tx_val;
    assign route_en = f.route;
endmodule

// File: rtl/gpio_pad_ctrl_chk.sv
module gpio_pad_ctrl_chk
    import gpio_pad_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [CFG_W-1:0]   rd_data,
    input logic               pad_out,
    input logic               pad_oe,
    input logic               evt,
    input logic [ROUTE_W-1:0] route_en
);
    // R1
    reset_word_chk: assert property (@(posedge clk)
        rst |=> (rd_data == RST_WORD && !pad_oe && !evt));

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~(WR_MASK | (32'h1 << B_RXST))) == '0);

    // R4
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_oe || pad_out) |-> (rd_data[B_MODE +: MODE_W] == '0)
                                && (pad_oe == !rd_data[B_TXDIS]));

    // R6
    edge_single_chk: assert property (@(posedge clk) disable iff (rst)
        (evt && rd_data[B_EVSEL +: 2] == 2'd1) |=> !(evt && rd_data[B_EVSEL +: 2] == 2'd1));

    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[B_EVSEL +: 2] == 2'd2) |-> !evt);

    // R10
    rx_off_chk: assert property (@(posedge clk) disable iff (rst)
        rd_data[B_RXDIS] |-> (!evt && !rd_data[B_RXST]));

    // R11
    native_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data[B_MODE +: MODE_W] != '0) |-> (!evt && !pad_oe && !pad_out));

    // R12
    route_pins_chk: assert property (@(posedge clk) disable iff (rst)
        route_en == rd_data[B_ROUTE +: ROUTE_W]);
endmodule

bind gpio_pad_ctrl gpio_pad_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_data  (rd_data),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .evt      (evt),
    .route_en (route_en)
);

// File: tb/sim_gpio_pad_ctrl.sv
module sim_gpio_pad_ctrl;
    import gpio_pad_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [31:0]      wr_data = '0;
    logic [31:0]      rd_data;
    logic             pad_in = 1'b0;
    logic             pad_out, pad_oe, evt;
    logic [3:0]       route_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model state
    logic [31:0] m_cfg = 32'h300;
    logic        m_s1 = 0, m_s2 = 0, m_prev = 0;

    always #10 clk = ~clk;

    gpio_pad_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .evt(evt), .route_en(route_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic cond_of(input logic [31:0] c, input logic s2);
        return !c[9] & (s2 ^ c[23]);
    endfunction

    function automatic logic exp_evt(input logic [31:0] c, input logic s2, input logic prev);
        logic cd;
        cd = cond_of(c, s2);
        if (c[13:10] != 4'd0 || c[9]) return 1'b0;
        case (c[26:25])
            2'd0: return cd;
            2'd1: return cd & !prev;
            2'd3: return cd ^ prev;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string evt_req(input logic [31:0] c);
        if (c[13:10] != 4'd0) return "R11";
        if (c[9]) return "R10";
        if (c[26:25] == 2'd2) return "R8";
        if (c[23]) return "R9";
        if (c[26:25] == 2'd0) return "R5";
        if (c[26:25] == 2'd1) return "R6";
        return "R7";
    endfunction

    task automatic compare_all();
        logic gm;
        gm = (m_cfg[13:10] == 4'd0);
        chk("R2", rd_data & ~32'h2, m_cfg);
        chk("R3", {31'b0, rd_data[1]}, {31'b0, m_s2 & !m_cfg[9]});
        chk("R4", {30'b0, pad_oe, pad_out}, {30'b0, gm & !m_cfg[8], gm & m_cfg[0]});
        chk("R12", {28'b0, route_en}, {28'b0, m_cfg[20:17]});
        chk(evt_req(m_cfg), {31'b0, evt}, {31'b0, exp_evt(m_cfg, m_s2, m_prev)});
    endtask

    task automatic step(input logic pin, input logic we, input logic [31:0] wd);
        @(negedge clk);
        pad_in  = pin;
        wr_en   = we;
        wr_data = wd;
        @(posedge clk);
        m_prev = cond_of(m_cfg, m_s2);
        m_s2   = m_s1;
        m_s1   = pin;
        if (we) m_cfg = wd & WR_MASK;
        #5;
        compare_all();
    endtask

    task automatic wr(input logic [31:0] wd);
        step(pad_in, 1'b1, wd);
    endtask

    task automatic run_pins(input logic [7:0] pins, input int n);
        for (int i = 0; i < n; i++) step(pins[i], 1'b0, 32'h0);
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240);
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state
        chk("R1", rd_data, 32'h300);
        chk("R1", {30'b0, pad_oe, evt}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #5;
        chk("R1", rd_data, 32'h300);
        compare_all();

        // R2: all ones written, only writable bits stick
        wr(32'hFFFF_FFFF);
        chk("R2", rd_data, 32'h069E_3F01);
        // R5: level mode, outputs enabled
        wr(32'h0000_0001);
        run_pins(8'b0011_0110, 8);
        // R6: rising edges
        wr(32'h0200_0000);
        run_pins(8'b0011_1100, 8);
        // R9: falling edges via inversion
        wr(32'h0280_0000);
        run_pins(8'b1100_0011, 8);
        // R9: active-low level
        wr(32'h0080_0000);
        run_pins(8'b1110_0001, 8);
        // R7: both edges
        wr(32'h0600_0000);
        run_pins(8'b0101_1001, 8);
        // R8: detection off
        wr(32'h0400_0000);
        run_pins(8'b1010_1010, 8);
        // R10: receiver off in both-edge mode
        wr(32'h0600_0200);
        run_pins(8'b1011_0010, 8);
        // R11: native mode
        wr(32'h0600_1401);
        run_pins(8'b0110_1101, 8);
        // R12 routing, R2 bit 1 write ignored
        wr(32'h001E_0002);
        chk("R2", rd_data & 32'h2, {30'b0, m_s2 & !m_cfg[9], 1'b0});
        run_pins(8'b0000_1111, 8);

        for (int i = 0; i < 2000; i++) begin
            logic [31:0] wd;
            logic        we;
            wd = $urandom();
            if (($urandom() % 4) != 0) wd[13:10] = 4'd0;
            if (($urandom() % 3) != 0) wd[9] = 1'b0;
            we = (($urandom() % 8) == 0);
            step(1'(($urandom() % 3) == 0 ? ~pad_in : pad_in), we, wd);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule